// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the working register store of a small 8-bit processor datapath. It holds thirty-two byte-wide registers. Two independent read ports return any register with no clock delay, and one synchronous byte write port updates one register per cycle. The decoder that drives the ports marks a byte write as an immediate-constant load when the instruction carries a literal. Only the upper sixteen registers accept such a load. An immediate load aimed below register 16 is reported on a flag output and changes nothing.

The top eight registers form four 16-bit pairs. One pair serves word add and subtract, and the other three are the indirect-address pointers. A word port reads the selected pair as a single value. In one cycle the same port can load the pair, add a small constant to it, or subtract a small constant from it, and both bytes change on the same edge. The three pointers are also driven out continuously, so the address path can use them with no read port. A separate port writes a 16-bit multiply product into registers 1 and 0. When two write sources target the same register in one cycle, a fixed priority decides which one lands.

Top module: `pair_regfile`

## Requirements
- R1: The file holds 32 registers of 8 bits, addressed 0 to 31. A byte write with `bwr_en`=1 and `bwr_imm`=0 stores `bwr_data` into register `bwr_addr` at the rising clock edge. Either read port returns the register that its address selects.
- R2: A byte write with `bwr_imm`=1 stores the value only when `bwr_addr` is 16 or higher. When `bwr_addr` is 0 to 15, `imm_illegal` is 1 in that cycle and no register changes. `imm_illegal` is 0 whenever `bwr_en`=0 or `bwr_imm`=0.
- R3: `x_ptr` = {reg27, reg26}, `y_ptr` = {reg29, reg28} and `z_ptr` = {reg31, reg30}. In each pair the higher-numbered register holds the high byte.
- R4: `wop_sel` selects a pair: 0 = 25:24, 1 = 27:26, 2 = 29:28, 3 = 31:30. `wop_mode` selects the operation: 0 = load `wop_data`, 1 = add `wop_k`, 2 = subtract `wop_k`, 3 = no operation. Both bytes of the pair take the 16-bit result, modulo 65536, on the same edge.
- R5: With `mul_en`=1, register 1 takes `mul_product[15:8]` and register 0 takes `mul_product[7:0]` at the edge.
- R6: When several writes target one register in the same cycle, the multiply write wins over the word write, and the word write wins over the byte write.
- R7: Reads show the stored value. A write in the current cycle becomes visible on the read outputs only after the edge.
- R8: Reset (`rst_n`=0, asynchronous) clears every register to zero.
- R9: `wrd_data` returns the pair selected by `wop_sel` as {high byte, low byte}, whatever the value of `wop_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Read port A address |
| rd_a_data | output | 8 | Read port A data |
| rd_b_addr | input | 5 | Read port B address |
| rd_b_data | output | 8 | Read port B data |
| bwr_en | input | 1 | Byte write enable |
| bwr_imm | input | 1 | Byte write is an immediate-constant load |
| bwr_addr | input | 5 | Byte write address |
| bwr_data | input | 8 | Byte write data |
| imm_illegal | output | 1 | Immediate load aimed at registers 0 to 15 |
| wop_sel | input | 2 | Word pair select |
| wop_mode | input | 2 | Word operation: load, add, subtract, none |
| wop_data | input | 16 | Word load value |
| wop_k | input | 6 | Word add or subtract constant |
| wrd_data | output | 16 | Selected pair value |
| mul_en | input | 1 | Multiply result write enable |
| mul_product | input | 16 | Multiply product for registers 1:0 |
| x_ptr | output | 16 | Pointer pair 27:26 |
| y_ptr | output | 16 | Pointer pair 29:28 |
| z_ptr | output | 16 | Pointer pair 31:30 |

## Verification
The bench subtracts 1 from 0x0000 and adds 1 to 0x00FF. A design that updated only one byte of a pair, or dropped the carry between the bytes, would return 0x00FF or 0x0000 in place of 0xFFFF and 0x0100. It sends an immediate load to register 5 and reads the register back. A guard that only raised the flag would leave the new byte in place. It also sends an immediate load to register 16 exactly, where a comparison that is off by one in either direction would flag a legal write or accept an illegal one. Byte writes collide with the multiply write on registers 0 and 1, and with word writes on the pairs. A design with the wrong priority would keep the byte value. Random traffic checks every cycle that the reads still show the value from before the edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int RF_WW = 16;

  typedef enum logic [1:0] {
    WOP_LOAD = 2'd0,
    WOP_ADD  = 2'd1,
    WOP_SUB  = 2'd2,
    WOP_NONE = 2'd3
  } wop_mode_e;

  // 16-bit pair arithmetic, wraps modulo 2^16
  function automatic logic [RF_WW-1:0] word_next(
    input wop_mode_e      mode,
    input logic [RF_WW-1:0] cur,
    input logic [RF_WW-1:0] load_val,
    input logic [RF_WW-1:0] k
  );
    logic [RF_WW-1:0] r;
    case (mode)
      WOP_LOAD: r = load_val;
      WOP_ADD:  r = cur + k;
      WOP_SUB:  r = cur - k;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rf_imm_guard.sv
module rf_imm_guard #(
  parameter int AW        = 5,
  parameter int IMM_FLOOR = 16
) (
  input  logic          bwr_en,
  input  logic          bwr_imm,
  input  logic [AW-1:0] bwr_addr,
  output logic          byte_ok,
  output logic          imm_bad
);
  logic below_floor;

  always_comb begin
    below_floor = (bwr_addr < AW'(IMM_FLOOR));
    imm_bad     = bwr_en && bwr_imm && below_floor;
    byte_ok     = bwr_en && !imm_bad;
  end
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic                     byte_ok,
  input  logic [AW-1:0]            bwr_addr,
  input  logic [DW-1:0]            bwr_data,
  input  logic                     word_en,
  input  logic [AW-1:0]            word_base,
  input  logic [2*DW-1:0]          word_val,
  input  logic                     mul_en,
  input  logic [2*DW-1:0]          mul_product,
  output logic [NREG-1:0]          we,
  output logic [NREG-1:0][DW-1:0]  wd
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic byte_hit, word_lo, word_hi, mul_lo, mul_hi;
    always_comb begin
      byte_hit = byte_ok && (bwr_addr == AW'(i));
      word_lo  = word_en && (word_base == AW'(i));
      word_hi  = word_en && (word_base + AW'(1) == AW'(i));
      mul_lo   = mul_en && (i == 0);
      mul_hi   = mul_en && (i == 1);
      we[i]    = byte_hit | word_lo | word_hi | mul_lo | mul_hi;
      // priority: multiply, then word, then byte
      if (mul_lo)       wd[i] = mul_product[DW-1:0];
      else if (mul_hi)  wd[i] = mul_product[2*DW-1:DW];
      else if (word_lo) wd[i] = word_val[DW-1:0];
      else if (word_hi) wd[i] = word_val[2*DW-1:DW];
      else              wd[i] = bwr_data;
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int NREG = 32,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         we,
  input  logic [NREG-1:0][DW-1:0] wd,
  output logic [NREG-1:0][DW-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wd[i];
    end
  end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int KW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_addr,
  output logic [7:0]      rd_a_data,
  input  logic [4:0]      rd_b_addr,
  output logic [7:0]      rd_b_data,
  input  logic            bwr_en,
  input  logic            bwr_imm,
  input  logic [4:0]      bwr_addr,
  input  logic [7:0]      bwr_data,
  output logic            imm_illegal,
  input  logic [1:0]      wop_sel,
  input  logic [1:0]      wop_mode,
  input  logic [15:0]     wop_data,
  input  logic [KW-1:0]   wop_k,
  output logic [15:0]     wrd_data,
  input  logic            mul_en,
  input  logic [15:0]     mul_product,
  output logic [15:0]     x_ptr,
  output logic [15:0]     y_ptr,
  output logic [15:0]     z_ptr
);
  import rf_pkg::*;

  localparam int AW        = $clog2(NREG);
  localparam int WW        = 2 * DW;
  localparam int PAIR_BASE = NREG - 8;
  localparam int X_LO      = NREG - 6;
  localparam int Y_LO      = NREG - 4;
  localparam int Z_LO      = NREG - 2;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] reg_wd;
  logic [NREG-1:0]         reg_we;
  logic                    byte_ok;
  logic                    word_en;
  logic [AW-1:0]           word_base;
  logic [WW-1:0]           word_cur;
  logic [WW-1:0]           word_val;
  wop_mode_e               wmode;

  rf_imm_guard #(.AW(AW), .IMM_FLOOR(NREG/2)) u_guard (
    .bwr_en   (bwr_en),
    .bwr_imm  (bwr_imm),
    .bwr_addr (bwr_addr),
    .byte_ok  (byte_ok),
    .imm_bad  (imm_illegal)
  );

  always_comb begin
    wmode     = wop_mode_e'(wop_mode);
    word_en   = (wmode != WOP_NONE);
    word_base = AW'(PAIR_BASE) + {wop_sel, 1'b0};
    word_cur  = {regs_q[word_base + AW'(1)], regs_q[word_base]};
    word_val  = word_next(wmode, word_cur, wop_data, WW'(wop_k));
  end

  rf_write_merge #(.NREG(NREG), .DW(DW), .AW(AW)) u_merge (
    .byte_ok     (byte_ok),
    .bwr_addr    (bwr_addr),
    .bwr_data    (bwr_data),
    .word_en     (word_en),
    .word_base   (word_base),
    .word_val    (word_val),
    .mul_en      (mul_en),
    .mul_product (mul_product),
    .we          (reg_we),
    .wd          (reg_wd)
  );

  rf_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .wd    (reg_wd),
    .q     (regs_q)
  );

  always_comb begin
    rd_a_data = regs_q[rd_a_addr];
    rd_b_data = regs_q[rd_b_addr];
    wrd_data  = word_cur;
    x_ptr     = {regs_q[X_LO+1], regs_q[X_LO]};
    y_ptr     = {regs_q[Y_LO+1], regs_q[Y_LO]};
    z_ptr     = {regs_q[Z_LO+1], regs_q[Z_LO]};
  end
endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0][7:0] regs_q,
  input logic             imm_illegal,
  input logic [4:0]       bwr_addr,
  input logic             mul_en,
  input logic [15:0]      mul_product,
  input logic [1:0]       wop_sel,
  input logic [1:0]       wop_mode,
  input logic [5:0]       wop_k,
  input logic [4:0]       rd_a_addr,
  input logic [7:0]       rd_a_data,
  input logic [15:0]      x_ptr
);
  AST_IMM_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_illegal && !mul_en) |=> regs_q[$past(bwr_addr)] == $past(regs_q[bwr_addr])); // R2

  AST_MUL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |=> {regs_q[1], regs_q[0]} == $past(mul_product)); // R5

  AST_WORD_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (wop_sel == 2'd0 && wop_mode == 2'd1) |=>
      {regs_q[25], regs_q[24]} == $past({regs_q[25], regs_q[24]} + {10'd0, wop_k})); // R4

  AST_WORD_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (wop_sel == 2'd0 && wop_mode == 2'd2) |=>
      {regs_q[25], regs_q[24]} == $past({regs_q[25], regs_q[24]} - {10'd0, wop_k})); // R4

  AST_XPTR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 5'd26) |-> rd_a_data == x_ptr[7:0]); // R3
endmodule

bind pair_regfile pair_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .regs_q      (regs_q),
  .imm_illegal (imm_illegal),
  .bwr_addr    (bwr_addr),
  .mul_en      (mul_en),
  .mul_product (mul_product),
  .wop_sel     (wop_sel),
  .wop_mode    (wop_mode),
  .wop_k       (wop_k),
  .rd_a_addr   (rd_a_addr),
  .rd_a_data   (rd_a_data),
  .x_ptr       (x_ptr)
);

// File: tb/pair_regfile_tb.sv
module pair_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, bwr_addr = '0;
  logic [7:0]  rd_a_data, rd_b_data, bwr_data = '0;
  logic        bwr_en = 1'b0, bwr_imm = 1'b0, mul_en = 1'b0;
  logic        imm_illegal;
  logic [1:0]  wop_sel = '0, wop_mode = 2'd3;
  logic [15:0] wop_data = '0, mul_product = '0;
  logic [5:0]  wop_k = '0;
  logic [15:0] wrd_data, x_ptr, y_ptr, z_ptr;

  int total = 0;
  int bad = 0;
  logic [7:0] model [32];

  always #2.5 clk = ~clk;

  pair_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .bwr_en(bwr_en), .bwr_imm(bwr_imm), .bwr_addr(bwr_addr), .bwr_data(bwr_data),
    .imm_illegal(imm_illegal),
    .wop_sel(wop_sel), .wop_mode(wop_mode), .wop_data(wop_data), .wop_k(wop_k),
    .wrd_data(wrd_data),
    .mul_en(mul_en), .mul_product(mul_product),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
  );

  function automatic int pair_lo(input logic [1:0] s);
    return 24 + 2 * int'(s);
  endfunction

  function automatic logic [15:0] pair_of(input int lo);
    return {model[lo+1], model[lo]};
  endfunction

  // expected word result using integer arithmetic
  function automatic logic [15:0] exp_word(input logic [1:0] m, input int cur,
                                           input int ld, input int k);
    int r;
    if (m == 2'd0)      r = ld;
    else if (m == 2'd1) r = (cur + k) % 65536;
    else if (m == 2'd2) r = (cur - k + 65536) % 65536;
    else                r = cur;
    return 16'(r);
  endfunction

  function automatic logic exp_illegal();
    return bwr_en && bwr_imm && (int'(bwr_addr) <= 15);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // check combinational outputs against the model (pre-edge state), then clock
  task automatic step();
    int lo;
    logic [15:0] wv;
    #1;
    chk("R1/R7 rd_a", {8'd0, rd_a_data}, {8'd0, model[rd_a_addr]});
    chk("R1/R7 rd_b", {8'd0, rd_b_data}, {8'd0, model[rd_b_addr]});
    chk("R9 wrd_data", wrd_data, pair_of(pair_lo(wop_sel)));
    chk("R3 x_ptr", x_ptr, pair_of(26));
    chk("R3 y_ptr", y_ptr, pair_of(28));
    chk("R3 z_ptr", z_ptr, pair_of(30));
    chk("R2 imm_illegal", {15'd0, imm_illegal}, {15'd0, exp_illegal()});
    lo = pair_lo(wop_sel);
    wv = exp_word(wop_mode, int'(pair_of(lo)), int'(wop_data), int'(wop_k));
    @(posedge clk);
    // R6 priority: byte, then word, then multiply overwrite
    if (bwr_en && !exp_illegal()) model[bwr_addr] = bwr_data;
    if (wop_mode != 2'd3) begin
      model[lo]   = wv[7:0];
      model[lo+1] = wv[15:8];
    end
    if (mul_en) begin
      model[0] = mul_product[7:0];
      model[1] = mul_product[15:8];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    bwr_en = 0; bwr_imm = 0; mul_en = 0; wop_mode = 2'd3;
  endtask

  task automatic read_at(input string req, input int a, input logic [7:0] exp);
    rd_a_addr = 5'(a);
    #1;
    chk(req, {8'd0, rd_a_data}, {8'd0, exp});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    @(negedge clk); @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 32; i++) read_at("R8 reset", i, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: immediate to register 5 blocked, to 16 accepted
    bwr_en = 1; bwr_imm = 1; bwr_addr = 5'd5; bwr_data = 8'hA5; rd_a_addr = 5'd5;
    step();
    idle(); read_at("R2 low imm ignored", 5, 8'h00);
    bwr_en = 1; bwr_imm = 1; bwr_addr = 5'd16; bwr_data = 8'h3C;
    step();
    idle(); read_at("R2 imm to 16", 16, 8'h3C);
    bwr_en = 1; bwr_imm = 0; bwr_addr = 5'd5; bwr_data = 8'h77;
    step();
    idle(); read_at("R1 byte write low reg", 5, 8'h77);

    // R4: borrow and carry across bytes on pair 25:24
    wop_sel = 2'd0; wop_mode = 2'd2; wop_k = 6'd1;
    step();
    idle(); #1 chk("R4 sub wrap", wrd_data, 16'hFFFF);
    wop_mode = 2'd0; wop_data = 16'h00FF;
    step();
    wop_mode = 2'd1; wop_k = 6'd1;
    step();
    idle(); #1 chk("R4 add carry", wrd_data, 16'h0100);

    // R3: pointer load via word port
    wop_sel = 2'd1; wop_mode = 2'd0; wop_data = 16'hBEEF;
    step();
    idle(); #1 chk("R3 x_ptr load", x_ptr, 16'hBEEF);

    // R6: multiply beats byte write on register 0; word beats byte on 30
    mul_en = 1; mul_product = 16'h1234; bwr_en = 1; bwr_addr = 5'd0; bwr_data = 8'hEE;
    step();
    idle(); read_at("R6 mul wins", 0, 8'h34); read_at("R5 mul high", 1, 8'h12);
    wop_sel = 2'd3; wop_mode = 2'd0; wop_data = 16'hCAFE;
    bwr_en = 1; bwr_addr = 5'd30; bwr_data = 8'h11;
    step();
    idle(); #1 chk("R6 word wins", z_ptr, 16'hCAFE);

    // R7: same-cycle write shows old value, new one after the edge
    bwr_en = 1; bwr_addr = 5'd20; bwr_data = 8'h5A; rd_a_addr = 5'd20;
    #1 chk("R7 old value", {8'd0, rd_a_data}, {8'd0, model[20]});
    step();
    idle(); read_at("R7 new value", 20, 8'h5A);

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      rd_a_addr   = 5'($urandom);
      rd_b_addr   = 5'($urandom);
      bwr_en      = 1'($urandom);
      bwr_imm     = 1'($urandom);
      bwr_addr    = ($urandom % 3 == 0) ? 5'(24 + $urandom % 8) : 5'($urandom);
      bwr_data    = 8'($urandom);
      wop_sel     = 2'($urandom);
      wop_mode    = 2'($urandom);
      wop_data    = 16'($urandom);
      wop_k       = 6'($urandom);
      mul_en      = ($urandom % 4 == 0);
      mul_product = 16'($urandom);
      step();
    end
    idle();
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule